// File: doc/BRIEF.md
# Extended Opcode Execution Sequencer

This block takes an opcode byte that the surrounding core has already fetched and runs the machine cycles for a small group of otherwise unassigned 8-bit opcodes. These are the word load and word store through DE, the two jumps that test the X5 flag, the conditional restart on V, the two immediate-offset loads into DE, and three register-pair arithmetic steps. The core hands over the opcode together with the PC (already pointing past the opcode byte), SP, HL, DE and the V and X5 flags. The sequencer then drives a byte-wide memory port, one clock per T-state. When it finishes, it returns the new register values with a write enable for each one.

Each machine cycle lasts a fixed number of T-states, and the opcode fetch counts as the first of them. For the conditional opcodes, the total number of states depends on the flag value sampled at start. The block reports the state count and the machine-cycle count, so the surrounding core can check its timing. The arithmetic opcodes do not compute anything here. They produce a single-cycle pass indication with an operation code, sent to the arithmetic unit. Any other opcode is refused with a one-cycle pulse and leaves every register untouched.

Top module: `ext_opcode_seq`

## Requirements
- R1: The handled opcodes and their encodings are: double subtract 08h, HL arithmetic right shift 10h, DE rotate left 18h, DE=HL+imm 28h, DE=SP+imm 38h, restart-on-V CBh, store HL via DE D9h, jump-if-X5-clear DDh, load HL via DE EDh, jump-if-X5-set FDh. Each one is accepted, runs, and ends with a done pulse that asserts pc_we_o.
- R2: Load via DE (EDh) reads address DE and then DE+1, returns HL = {second byte, first byte}, and takes 10 states in 3 machine cycles.
- R3: Store via DE (D9h) writes L to DE and then H to DE+1, changes no register except PC (written back unchanged), and takes 10 states in 3 machine cycles.
- R4: Restart-on-V with V=1 writes PC[15:8] to SP-1, then PC[7:0] to SP-2, returns SP-2 and PC=0040h, and takes 12 states in 3 machine cycles.
- R5: Restart-on-V with V=0 performs no bus access, returns PC unchanged, and takes 6 states in 1 machine cycle.
- R6: A taken X5 jump (FDh with X5=1, DDh with X5=0) reads the low byte at PC and the high byte at PC+1, loads PC with {high, low}, and takes 10 states in 3 machine cycles.
- R7: A jump that is not taken reads only the low byte at PC, returns PC+2, and takes 7 states in 2 machine cycles.
- R8: The two offset loads (28h, 38h) read one byte at PC and return DE = HL or SP plus that byte (zero-extended, modulo 2^16). They return PC+1 and take 10 states in 3 machine cycles.
- R9: The arithmetic opcodes cause no bus access and pulse alu_pass_o together with done_o. They put alu_op_o = 1 for 08h, 2 for 10h and 3 for 18h, with 10, 7 and 10 states respectively, all in 3 machine cycles.
- R10: Any other opcode pulses unhandled_o in the cycle after acceptance. It causes no busy, no done, no bus access and no register write enable.
- R11: Addresses DE+1, PC+1, SP-1 and SP-2 wrap modulo 2^16, so DE=FFFFh makes the second access go to 0000h.
- R12: A start is accepted only when busy_o is low. busy_o then stays high for exactly tstates_o cycles, and done_o marks the last of them. A start presented while busy has no effect.
- R13: Each memory access is a single-cycle read or write strobe, never both at once. It occurs in the second state of its machine cycle and is never present while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one T-state per cycle |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Opcode valid; accepted when idle |
| opcode_i | input | 8 | Fetched opcode byte |
| flag_v_i | input | 1 | Signed overflow flag |
| flag_x5_i | input | 1 | X5 flag |
| pc_i | input | 16 | PC pointing past the opcode |
| sp_i | input | 16 | Stack pointer |
| hl_i | input | 16 | HL pair |
| de_i | input | 16 | DE pair |
| mem_rdata_i | input | 8 | Read data, sampled at the end of the read strobe cycle |
| mem_addr_o | output | 16 | Memory address |
| mem_rd_o | output | 1 | Read strobe |
| mem_wr_o | output | 1 | Write strobe |
| mem_wdata_o | output | 8 | Write data |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Last state of the sequence |
| unhandled_o | output | 1 | Opcode refused |
| pc_o | output | 16 | New PC |
| pc_we_o | output | 1 | PC write enable |
| sp_o | output | 16 | New SP |
| sp_we_o | output | 1 | SP write enable |
| hl_o | output | 16 | New HL |
| hl_we_o | output | 1 | HL write enable |
| de_o | output | 16 | New DE |
| de_we_o | output | 1 | DE write enable |
| alu_pass_o | output | 1 | Arithmetic pass request |
| alu_op_o | output | 2 | Arithmetic operation code |
| tstates_o | output | 4 | States used by the current or last sequence |
| mcycles_o | output | 2 | Machine cycles used by the current or last sequence |

## Verification
The assertions assume two things. First, the core samples the write-back values only while done_o is high. Second, read data is valid by the end of the strobe cycle. The bench satisfies both: it answers each read strobe at the falling edge from its own memory, and it inspects results only at done_o. The assertions also assume that the flags and register inputs matter only in the accept cycle. The bench changes them only between sequences, except in one run where the opcode and start stay asserted during a sequence. That run shows the start is ignored while busy.

// File: rtl/ext_seq_pkg.sv
package ext_seq_pkg;
  localparam int DATA_W = 8;
  localparam int WORD_W = 2 * DATA_W;
  localparam int MC_MAX = 3;
  localparam int MC_W   = $clog2(MC_MAX + 1);
  localparam int LEN_W  = 3;
  localparam int TST_W  = 4;

  localparam logic [DATA_W-1:0] OPC_DSUB = 8'h08;
  localparam logic [DATA_W-1:0] OPC_ARHL = 8'h10;
  localparam logic [DATA_W-1:0] OPC_RDEL = 8'h18;
  localparam logic [DATA_W-1:0] OPC_LDHI = 8'h28;
  localparam logic [DATA_W-1:0] OPC_LDSI = 8'h38;
  localparam logic [DATA_W-1:0] OPC_RSTV = 8'hCB;
  localparam logic [DATA_W-1:0] OPC_SHLX = 8'hD9;
  localparam logic [DATA_W-1:0] OPC_JNX5 = 8'hDD;
  localparam logic [DATA_W-1:0] OPC_LHLX = 8'hED;
  localparam logic [DATA_W-1:0] OPC_JX5  = 8'hFD;

  typedef enum logic [3:0] {
    OP_NONE, OP_DSUB, OP_ARHL, OP_RDEL, OP_LDHI, OP_LDSI,
    OP_RSTV, OP_SHLX, OP_LHLX, OP_JX5, OP_JNX5
  } op_e;

  typedef enum logic [1:0] {MC_INT, MC_RD, MC_WR} mc_kind_e;

  typedef enum logic [1:0] {ALU_NONE = 2'd0, ALU_DSUB = 2'd1, ALU_ARHL = 2'd2, ALU_RDEL = 2'd3} alu_op_e;

  typedef struct packed {
    logic                         valid;
    op_e                          op;
    logic                         taken;
    logic [MC_W-1:0]              n_mc;
    mc_kind_e [MC_MAX-1:0]        kind;
    logic [MC_MAX-1:0][LEN_W-1:0] len;
  } plan_t;

  function automatic plan_t mk_plan(op_e op, logic tk, logic [MC_W-1:0] n,
                                    logic [LEN_W-1:0] l0,
                                    mc_kind_e k1, logic [LEN_W-1:0] l1,
                                    mc_kind_e k2, logic [LEN_W-1:0] l2);
    plan_t p;
    p.valid   = 1'b1;
    p.op      = op;
    p.taken   = tk;
    p.n_mc    = n;
    p.kind[0] = MC_INT;
    p.kind[1] = k1;
    p.kind[2] = k2;
    p.len[0]  = l0;
    p.len[1]  = l1;
    p.len[2]  = l2;
    return p;
  endfunction
endpackage

// File: rtl/ext_seq_decode.sv
module ext_seq_decode
  import ext_seq_pkg::*;
(
  input  logic [DATA_W-1:0] opcode_i,
  input  logic              flag_v_i,
  input  logic              flag_x5_i,
  output plan_t             plan_o,
  output logic [TST_W-1:0]  tstates_o
);
  logic jmp_set, jmp_clr;

  assign jmp_set = flag_x5_i;
  assign jmp_clr = ~flag_x5_i;

  always_comb begin
    plan_o = '0;
    case (opcode_i)
      OPC_DSUB: plan_o = mk_plan(OP_DSUB, 1'b0, 2'd3, 3'd4, MC_INT, 3'd3, MC_INT, 3'd3);
      OPC_ARHL: plan_o = mk_plan(OP_ARHL, 1'b0, 2'd3, 3'd4, MC_INT, 3'd2, MC_INT, 3'd1);
      OPC_RDEL: plan_o = mk_plan(OP_RDEL, 1'b0, 2'd3, 3'd4, MC_INT, 3'd3, MC_INT, 3'd3);
      OPC_LDHI: plan_o = mk_plan(OP_LDHI, 1'b0, 2'd3, 3'd4, MC_RD,  3'd3, MC_INT, 3'd3);
      OPC_LDSI: plan_o = mk_plan(OP_LDSI, 1'b0, 2'd3, 3'd4, MC_RD,  3'd3, MC_INT, 3'd3);
      OPC_SHLX: plan_o = mk_plan(OP_SHLX, 1'b0, 2'd3, 3'd4, MC_WR,  3'd3, MC_WR,  3'd3);
      OPC_LHLX: plan_o = mk_plan(OP_LHLX, 1'b0, 2'd3, 3'd4, MC_RD,  3'd3, MC_RD,  3'd3);
      OPC_RSTV: begin
        if (flag_v_i) plan_o = mk_plan(OP_RSTV, 1'b1, 2'd3, 3'd6, MC_WR, 3'd3, MC_WR, 3'd3);
        else          plan_o = mk_plan(OP_RSTV, 1'b0, 2'd1, 3'd6, MC_INT, 3'd0, MC_INT, 3'd0);
      end
      OPC_JX5: begin
        if (jmp_set) plan_o = mk_plan(OP_JX5, 1'b1, 2'd3, 3'd4, MC_RD, 3'd3, MC_RD, 3'd3);
        else         plan_o = mk_plan(OP_JX5, 1'b0, 2'd2, 3'd4, MC_RD, 3'd3, MC_INT, 3'd0);
      end
      OPC_JNX5: begin
        if (jmp_clr) plan_o = mk_plan(OP_JNX5, 1'b1, 2'd3, 3'd4, MC_RD, 3'd3, MC_RD, 3'd3);
        else         plan_o = mk_plan(OP_JNX5, 1'b0, 2'd2, 3'd4, MC_RD, 3'd3, MC_INT, 3'd0);
      end
      default: plan_o = '0;
    endcase
  end

  // total states = sum of the lengths of the cycles in use
  always_comb begin
    tstates_o = '0;
    for (int i = 0; i < MC_MAX; i++) begin
      if (MC_W'(i) < plan_o.n_mc) tstates_o = tstates_o + TST_W'(plan_o.len[i]);
    end
  end
endmodule

// File: rtl/ext_seq_timer.sv
module ext_seq_timer
  import ext_seq_pkg::*;
(
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         load_i,
  input  logic [MC_W-1:0]              n_mc_i,
  input  logic [MC_MAX-1:0][LEN_W-1:0] len_i,
  output logic                         active_o,
  output logic [MC_W-1:0]              mc_idx_o,
  output logic [LEN_W-1:0]             tcnt_o,
  output logic                         last_o
);
  logic                active_q;
  logic [MC_W-1:0]     mc_q;
  logic [LEN_W-1:0]    tcnt_q;
  logic [LEN_W-1:0]    cur_len;
  logic                end_mc, last_mc;

  always_comb begin
    cur_len = '0;
    for (int i = 0; i < MC_MAX; i++) begin
      if (mc_q == MC_W'(i)) cur_len = len_i[i];
    end
  end

  assign end_mc  = (tcnt_q == cur_len - LEN_W'(1));
  assign last_mc = (mc_q == n_mc_i - MC_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      mc_q     <= '0;
      tcnt_q   <= '0;
    end else if (load_i) begin
      active_q <= 1'b1;
      mc_q     <= '0;
      tcnt_q   <= '0;
    end else if (active_q) begin
      if (end_mc) begin
        tcnt_q <= '0;
        if (last_mc) begin
          active_q <= 1'b0;
          mc_q     <= '0;
        end else begin
          mc_q <= mc_q + MC_W'(1);
        end
      end else begin
        tcnt_q <= tcnt_q + LEN_W'(1);
      end
    end
  end

  assign active_o = active_q;
  assign mc_idx_o = mc_q;
  assign tcnt_o   = tcnt_q;
  assign last_o   = active_q && end_mc && last_mc;

  assert_state_in_cycle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> (tcnt_q < cur_len) && (mc_q < n_mc_i));
endmodule

// File: rtl/ext_seq_bus.sv
module ext_seq_bus
  import ext_seq_pkg::*;
(
  input  logic              active_i,
  input  op_e               op_i,
  input  mc_kind_e          kind_i,
  input  logic [MC_W-1:0]   mc_idx_i,
  input  logic [LEN_W-1:0]  tcnt_i,
  input  logic [WORD_W-1:0] pc_i,
  input  logic [WORD_W-1:0] sp_i,
  input  logic [WORD_W-1:0] hl_i,
  input  logic [WORD_W-1:0] de_i,
  output logic [WORD_W-1:0] addr_o,
  output logic              rd_o,
  output logic              wr_o,
  output logic [DATA_W-1:0] wdata_o
);
  logic strobe, second, mem_cyc;

  assign mem_cyc = active_i && (kind_i != MC_INT);
  assign strobe  = mem_cyc && (tcnt_i == LEN_W'(1));
  assign second  = (mc_idx_i == MC_W'(2));
  assign rd_o    = strobe && (kind_i == MC_RD);
  assign wr_o    = strobe && (kind_i == MC_WR);

  always_comb begin
    addr_o  = '0;
    wdata_o = '0;
    if (mem_cyc) begin
      case (op_i)
        OP_LHLX, OP_SHLX: addr_o = second ? de_i + WORD_W'(1) : de_i;
        OP_LDHI, OP_LDSI, OP_JX5, OP_JNX5: addr_o = second ? pc_i + WORD_W'(1) : pc_i;
        OP_RSTV: addr_o = second ? sp_i - WORD_W'(2) : sp_i - WORD_W'(1);
        default: addr_o = '0;
      endcase
      case (op_i)
        OP_SHLX: wdata_o = second ? hl_i[WORD_W-1:DATA_W] : hl_i[DATA_W-1:0];
        OP_RSTV: wdata_o = second ? pc_i[DATA_W-1:0] : pc_i[WORD_W-1:DATA_W];
        default: wdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/ext_opcode_seq.sv
module ext_opcode_seq
  import ext_seq_pkg::*;
#(
  parameter logic [15:0] RST_VEC = 16'h0040
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [DATA_W-1:0]  opcode_i,
  input  logic               flag_v_i,
  input  logic               flag_x5_i,
  input  logic [WORD_W-1:0]  pc_i,
  input  logic [WORD_W-1:0]  sp_i,
  input  logic [WORD_W-1:0]  hl_i,
  input  logic [WORD_W-1:0]  de_i,
  input  logic [DATA_W-1:0]  mem_rdata_i,
  output logic [WORD_W-1:0]  mem_addr_o,
  output logic               mem_rd_o,
  output logic               mem_wr_o,
  output logic [DATA_W-1:0]  mem_wdata_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               unhandled_o,
  output logic [WORD_W-1:0]  pc_o,
  output logic               pc_we_o,
  output logic [WORD_W-1:0]  sp_o,
  output logic               sp_we_o,
  output logic [WORD_W-1:0]  hl_o,
  output logic               hl_we_o,
  output logic [WORD_W-1:0]  de_o,
  output logic               de_we_o,
  output logic               alu_pass_o,
  output logic [1:0]         alu_op_o,
  output logic [TST_W-1:0]   tstates_o,
  output logic [MC_W-1:0]    mcycles_o
);
  plan_t              plan_d, plan_q;
  logic [TST_W-1:0]   tst_d, tst_q;
  logic [WORD_W-1:0]  pc_q, sp_q, hl_q, de_q;
  logic [DATA_W-1:0]  byte_lo_q, byte_hi_q;
  logic               unh_q, accept, load;
  logic               active, last;
  logic [MC_W-1:0]    mc_idx;
  logic [LEN_W-1:0]   tcnt;
  mc_kind_e           cur_kind;
  logic [WORD_W-1:0]  pc_n, sp_n, hl_n, de_n;
  logic               sp_w, hl_w, de_w;
  alu_op_e            alu_n;

  ext_seq_decode u_decode (
    .opcode_i  (opcode_i),
    .flag_v_i  (flag_v_i),
    .flag_x5_i (flag_x5_i),
    .plan_o    (plan_d),
    .tstates_o (tst_d)
  );

  assign accept = start_i && !active;
  assign load   = accept && plan_d.valid;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      plan_q <= '0;
      tst_q  <= '0;
      pc_q   <= '0;
      sp_q   <= '0;
      hl_q   <= '0;
      de_q   <= '0;
      unh_q  <= 1'b0;
    end else begin
      unh_q <= accept && !plan_d.valid;
      if (load) begin
        plan_q <= plan_d;
        tst_q  <= tst_d;
        pc_q   <= pc_i;
        sp_q   <= sp_i;
        hl_q   <= hl_i;
        de_q   <= de_i;
      end
    end
  end

  ext_seq_timer u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .n_mc_i   (plan_q.n_mc),
    .len_i    (plan_q.len),
    .active_o (active),
    .mc_idx_o (mc_idx),
    .tcnt_o   (tcnt),
    .last_o   (last)
  );

  always_comb begin
    cur_kind = MC_INT;
    for (int i = 0; i < MC_MAX; i++) begin
      if (mc_idx == MC_W'(i)) cur_kind = plan_q.kind[i];
    end
  end

  ext_seq_bus u_bus (
    .active_i (active),
    .op_i     (plan_q.op),
    .kind_i   (cur_kind),
    .mc_idx_i (mc_idx),
    .tcnt_i   (tcnt),
    .pc_i     (pc_q),
    .sp_i     (sp_q),
    .hl_i     (hl_q),
    .de_i     (de_q),
    .addr_o   (mem_addr_o),
    .rd_o     (mem_rd_o),
    .wr_o     (mem_wr_o),
    .wdata_o  (mem_wdata_o)
  );

  // read data lands at the end of the strobe cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_lo_q <= '0;
      byte_hi_q <= '0;
    end else if (mem_rd_o) begin
      if (mc_idx == MC_W'(1)) byte_lo_q <= mem_rdata_i;
      else                    byte_hi_q <= mem_rdata_i;
    end
  end

  always_comb begin
    pc_n  = pc_q;
    sp_n  = sp_q;
    hl_n  = hl_q;
    de_n  = de_q;
    sp_w  = 1'b0;
    hl_w  = 1'b0;
    de_w  = 1'b0;
    alu_n = ALU_NONE;
    case (plan_q.op)
      OP_LHLX: begin
        hl_n = {byte_hi_q, byte_lo_q};
        hl_w = 1'b1;
      end
      OP_LDHI: begin
        de_n = hl_q + {{(WORD_W-DATA_W){1'b0}}, byte_lo_q};
        de_w = 1'b1;
        pc_n = pc_q + WORD_W'(1);
      end
      OP_LDSI: begin
        de_n = sp_q + {{(WORD_W-DATA_W){1'b0}}, byte_lo_q};
        de_w = 1'b1;
        pc_n = pc_q + WORD_W'(1);
      end
      OP_JX5, OP_JNX5: pc_n = plan_q.taken ? {byte_hi_q, byte_lo_q} : pc_q + WORD_W'(2);
      OP_RSTV: begin
        if (plan_q.taken) begin
          pc_n = RST_VEC;
          sp_n = sp_q - WORD_W'(2);
          sp_w = 1'b1;
        end
      end
      OP_DSUB: alu_n = ALU_DSUB;
      OP_ARHL: alu_n = ALU_ARHL;
      OP_RDEL: alu_n = ALU_RDEL;
      default: ;
    endcase
  end

  assign busy_o      = active;
  assign done_o      = last;
  assign unhandled_o = unh_q;
  assign pc_o        = pc_n;
  assign sp_o        = sp_n;
  assign hl_o        = hl_n;
  assign de_o        = de_n;
  assign pc_we_o     = last;
  assign sp_we_o     = last && sp_w;
  assign hl_we_o     = last && hl_w;
  assign de_we_o     = last && de_w;
  assign alu_pass_o  = last && (alu_n != ALU_NONE);
  assign alu_op_o    = alu_pass_o ? alu_n : ALU_NONE;
  assign tstates_o   = tst_q;
  assign mcycles_o   = plan_q.n_mc;

  // independent count of busy cycles, checked against the reported total
  logic [TST_W:0] busy_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      busy_cnt_q <= '0;
    else if (!busy_o) busy_cnt_q <= '0;
    else              busy_cnt_q <= busy_cnt_q + (TST_W+1)'(1);
  end

  assert_busy_len_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (busy_cnt_q + (TST_W+1)'(1) == {1'b0, tstates_o}));
  assert_done_ends_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
  assert_idle_bus_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_rd_o && !mem_wr_o);
  assert_rw_excl_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));
  assert_strobe_pulse_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o || mem_wr_o) |=> !mem_rd_o && !mem_wr_o);
  assert_unh_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unhandled_o |-> !busy_o && !pc_we_o && !sp_we_o && !hl_we_o && !de_we_o);
  assert_alu_only_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alu_pass_o |-> done_o && !mem_rd_o && !mem_wr_o);
endmodule

// File: tb/ext_opcode_seq_tb_top.sv
module ext_opcode_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  opcode_i = 8'h00;
  logic        flag_v_i = 1'b0, flag_x5_i = 1'b0;
  logic [15:0] pc_i = '0, sp_i = '0, hl_i = '0, de_i = '0;
  logic [7:0]  mem_rdata_i = '0;
  logic [15:0] mem_addr_o, pc_o, sp_o, hl_o, de_o;
  logic        mem_rd_o, mem_wr_o, busy_o, done_o, unhandled_o;
  logic [7:0]  mem_wdata_o;
  logic        pc_we_o, sp_we_o, hl_we_o, de_we_o, alu_pass_o;
  logic [1:0]  alu_op_o, mcycles_o;
  logic [3:0]  tstates_o;

  always #2 clk = ~clk;

  ext_opcode_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .opcode_i(opcode_i),
    .flag_v_i(flag_v_i), .flag_x5_i(flag_x5_i), .pc_i(pc_i), .sp_i(sp_i),
    .hl_i(hl_i), .de_i(de_i), .mem_rdata_i(mem_rdata_i), .mem_addr_o(mem_addr_o),
    .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o), .mem_wdata_o(mem_wdata_o),
    .busy_o(busy_o), .done_o(done_o), .unhandled_o(unhandled_o),
    .pc_o(pc_o), .pc_we_o(pc_we_o), .sp_o(sp_o), .sp_we_o(sp_we_o),
    .hl_o(hl_o), .hl_we_o(hl_we_o), .de_o(de_o), .de_we_o(de_we_o),
    .alu_pass_o(alu_pass_o), .alu_op_o(alu_op_o), .tstates_o(tstates_o),
    .mcycles_o(mcycles_o)
  );

  typedef struct {
    int kind;   // 0 read, 1 write, 2 done, 3 unhandled
    int t;
    int addr; int data;
    int pc; int sp; int hl; int de;
    int we;     // 8 pc, 4 sp, 2 hl, 1 de
    int alu; int tst; int mc;
    string req;
  } exp_t;

  exp_t q[$];
  logic [7:0] mem [int];
  int n_chk = 0, n_fail = 0, t_cnt = 0;
  bit finished = 0;
  int r_pc, r_sp, r_hl, r_de;

  function automatic int rd(int a);
    return mem.exists(a & 16'hFFFF) ? int'(mem[a & 16'hFFFF]) : 0;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic exp_t blank(string req);
    exp_t e;
    e.kind = 0; e.t = 0; e.addr = 0; e.data = 0; e.pc = 0; e.sp = 0; e.hl = 0;
    e.de = 0; e.we = 0; e.alu = 0; e.tst = 0; e.mc = 0; e.req = req;
    return e;
  endfunction

  task automatic push_bus(string req, int kind, int t, int addr, int data);
    exp_t e = blank(req);
    e.kind = kind; e.t = t; e.addr = addr & 16'hFFFF; e.data = data & 8'hFF;
    q.push_back(e);
  endtask

  task automatic push_done(string req, int t, int pc, int sp, int hl, int de,
                           int we, int alu, int mc);
    exp_t e = blank(req);
    e.kind = 2; e.t = t; e.pc = pc & 16'hFFFF; e.sp = sp & 16'hFFFF;
    e.hl = hl & 16'hFFFF; e.de = de & 16'hFFFF; e.we = we; e.alu = alu;
    e.tst = t; e.mc = mc;
    q.push_back(e);
  endtask

  // driver: computes expectations from the requirements, then starts the block
  task automatic issue(logic [7:0] op, bit v, bit x5, bit hold);
    int lo, hi;
    case (op)
      8'hED: begin // R2, R11
        lo = rd(r_de); hi = rd(r_de + 1);
        push_bus("R2", 0, 6, r_de, lo);
        push_bus("R11", 0, 9, r_de + 1, hi);
        push_done("R2", 10, r_pc, r_sp, (hi << 8) | lo, r_de, 8 | 2, 0, 3);
      end
      8'hD9: begin // R3
        push_bus("R3", 1, 6, r_de, r_hl);
        push_bus("R11", 1, 9, r_de + 1, r_hl >> 8);
        push_done("R3", 10, r_pc, r_sp, r_hl, r_de, 8, 0, 3);
      end
      8'hCB: begin
        if (v) begin // R4
          push_bus("R4", 1, 8, r_sp - 1, r_pc >> 8);
          push_bus("R4", 1, 11, r_sp - 2, r_pc);
          push_done("R4", 12, 16'h0040, r_sp - 2, r_hl, r_de, 8 | 4, 0, 3);
        end else begin // R5
          push_done("R5", 6, r_pc, r_sp, r_hl, r_de, 8, 0, 1);
        end
      end
      8'hFD, 8'hDD: begin
        lo = rd(r_pc); hi = rd(r_pc + 1);
        if ((op == 8'hFD) == x5) begin // R6
          push_bus("R6", 0, 6, r_pc, lo);
          push_bus("R6", 0, 9, r_pc + 1, hi);
          push_done("R6", 10, (hi << 8) | lo, r_sp, r_hl, r_de, 8, 0, 3);
        end else begin // R7
          push_bus("R7", 0, 6, r_pc, lo);
          push_done("R7", 7, r_pc + 2, r_sp, r_hl, r_de, 8, 0, 2);
        end
      end
      8'h28, 8'h38: begin // R8
        lo = rd(r_pc);
        push_bus("R8", 0, 6, r_pc, lo);
        push_done("R8", 10, r_pc + 1, r_sp, r_hl,
                  ((op == 8'h28) ? r_hl : r_sp) + lo, 8 | 1, 0, 3);
      end
      8'h08: push_done("R9", 10, r_pc, r_sp, r_hl, r_de, 8, 1, 3);
      8'h10: push_done("R9", 7, r_pc, r_sp, r_hl, r_de, 8, 2, 3);
      8'h18: push_done("R9", 10, r_pc, r_sp, r_hl, r_de, 8, 3, 3);
      default: begin // R10
        exp_t e = blank("R10");
        e.kind = 3;
        q.push_back(e);
      end
    endcase
    @(posedge clk); #1;
    start_i = 1'b1; opcode_i = op; flag_v_i = v; flag_x5_i = x5;
    pc_i = r_pc[15:0]; sp_i = r_sp[15:0]; hl_i = r_hl[15:0]; de_i = r_de[15:0];
    @(posedge clk); #1;
    if (hold) begin // R12: start and a refused opcode held during busy
      opcode_i = 8'h00;
      repeat (3) @(posedge clk);
      #1;
    end
    start_i = 1'b0;
    flag_v_i = ~v; flag_x5_i = ~x5; pc_i = 16'h5A5A; de_i = 16'hA5A5;
    repeat (15) @(posedge clk);
  endtask

  // monitor: pops expected items as the design produces them
  always @(negedge clk) begin
    if (rst_n) begin
      exp_t e;
      if (busy_o) t_cnt = t_cnt + 1; else t_cnt = 0;
      if (mem_rd_o || mem_wr_o) begin
        if (q.size() == 0) chk("R13", "unexpected strobe", 1, 0);
        else begin
          e = q.pop_front();
          chk(e.req, "bus kind", mem_wr_o ? 1 : 0, e.kind);
          chk(e.req, "bus state", t_cnt, e.t);
          chk(e.req, "bus addr", int'(mem_addr_o), e.addr);
          if (mem_wr_o) begin
            chk(e.req, "write data", int'(mem_wdata_o), e.data);
            mem[int'(mem_addr_o)] = mem_wdata_o;
          end else begin
            mem_rdata_i = 8'(rd(int'(mem_addr_o)));
          end
        end
      end
      if (done_o) begin
        if (q.size() == 0) chk("R12", "unexpected done", 1, 0);
        else begin
          e = q.pop_front();
          chk(e.req, "done kind", 2, e.kind);
          chk(e.req, "done state", t_cnt, e.t);
          chk(e.req, "tstates", int'(tstates_o), e.tst);
          chk(e.req, "mcycles", int'(mcycles_o), e.mc);
          chk(e.req, "write enables", {pc_we_o, sp_we_o, hl_we_o, de_we_o}, e.we);
          chk(e.req, "pc", int'(pc_o), e.pc);
          if (e.we & 4) chk(e.req, "sp", int'(sp_o), e.sp);
          if (e.we & 2) chk(e.req, "hl", int'(hl_o), e.hl);
          if (e.we & 1) chk(e.req, "de", int'(de_o), e.de);
          chk(e.req, "alu pass", int'(alu_pass_o), (e.alu != 0) ? 1 : 0);
          chk(e.req, "alu op", int'(alu_op_o), e.alu);
        end
      end
      if (unhandled_o) begin
        if (q.size() == 0) chk("R10", "unexpected unhandled", 1, 0);
        else begin
          e = q.pop_front();
          chk(e.req, "unhandled kind", 3, e.kind);
          chk("R10", "busy/we on refusal",
              {busy_o, done_o, pc_we_o, sp_we_o, hl_we_o, de_we_o}, 0);
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // reset state
    chk("R12", "reset busy/done", {busy_o, done_o}, 0);
    chk("R13", "reset strobes", {mem_rd_o, mem_wr_o}, 0);
    chk("R10", "reset unhandled", int'(unhandled_o), 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    r_pc = 16'h1001; r_sp = 16'h8000; r_hl = 16'hBEEF; r_de = 16'h1234;
    mem[16'h1234] = 8'hCD; mem[16'h1235] = 8'hAB;
    issue(8'hED, 0, 0, 0);                      // R2 load via DE
    r_de = 16'hFFFF; mem[16'hFFFF] = 8'h11; mem[16'h0000] = 8'h22;
    issue(8'hED, 0, 0, 0);                      // R11 wrap on read
    r_de = 16'h2000;
    issue(8'hD9, 0, 0, 0);                      // R3 store via DE
    r_de = 16'hFFFF; r_hl = 16'h3C4D;
    issue(8'hD9, 0, 0, 0);                      // R11 wrap on write
    chk("R11", "wrapped write high byte", rd(0), 8'h3C);
    r_pc = 16'h1235; r_sp = 16'h8000;
    issue(8'hCB, 1, 0, 0);                      // R4 restart taken
    issue(8'hCB, 0, 1, 0);                      // R5 restart skipped
    r_sp = 16'h0001;
    issue(8'hCB, 1, 1, 0);                      // R4/R11 stack wrap
    r_pc = 16'h3001; mem[16'h3001] = 8'h78; mem[16'h3002] = 8'h56;
    issue(8'hFD, 0, 1, 0);                      // R6 jump on X5 set
    issue(8'hFD, 1, 0, 0);                      // R7 not taken
    issue(8'hDD, 0, 0, 0);                      // R6 jump on X5 clear
    issue(8'hDD, 0, 1, 0);                      // R7 not taken
    r_hl = 16'h10F0; mem[16'h3001] = 8'h20;
    issue(8'h28, 0, 0, 0);                      // R8 DE=HL+imm
    r_sp = 16'hFFF0; mem[16'h3001] = 8'hFF;
    issue(8'h38, 0, 0, 0);                      // R8 DE=SP+imm with wrap
    issue(8'h08, 0, 0, 0);                      // R9
    issue(8'h10, 1, 1, 0);                      // R9
    issue(8'h18, 0, 0, 0);                      // R9
    issue(8'h00, 1, 1, 0);                      // R10
    issue(8'hC3, 0, 0, 0);                      // R10
    issue(8'h20, 0, 0, 0);                      // R10
    r_de = 16'h1234;
    issue(8'hED, 0, 0, 1);                      // R12 start ignored while busy
    issue(8'hFD, 0, 0, 0);                      // R1 back-to-back after hold
    chk("R1", "expected items left", q.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL R12 watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule